// File: doc/BRIEF.md
# Pending Store Address Tracker

This block sits beside a relaxed-ordering memory path that has no store FIFO: stores and loads go straight to the cache. A store that still lacks coherence write permission occupies a miss register, and this tracker keeps one entry per such store. Each entry holds a live bit and the store's address. The block returns the index it picked at allocation. The cache later names that index when the store has updated the cache, and the entry is then freed.

Every issuing load is compared with the live addresses. On a match the load is told to stall. The load is never served from the pending store. A Fence request completes only after every live entry has drained. A Fence that arrives in the same cycle as a new store also waits for that store, as program order requires.

Top module: `store_addr_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no entry is live: `ld_stall`, `full` and `fence_done` are all low.
- R2: An accepted store takes the lowest-numbered free entry. That index is shown on `st_idx` in the same cycle, and the entry is live from the next cycle on.
- R3: `full` is high exactly when all `NUM_ENTRIES` entries are live. A store request made while `full` is high is ignored: it creates no entry and cannot cause a later load to stall.
- R4: `ld_stall` is high exactly when `ld_valid` is high and `ld_addr` equals the address of at least one entry that is live at the start of the cycle and is not completed in that cycle. Duplicate addresses are allowed, and the stall holds while any matching entry stays live. An entry allocated in the same cycle does not cause a stall.
- R5: A completion on `done_idx` frees that entry from the next cycle on. A load to the same address in the completion cycle is not stalled. A completion that names a free entry has no effect.
- R6: A Fence request stays active from the `fence_req` pulse until the cycle in which no entry will be live after that cycle's completions and allocations. In that cycle `fence_done` pulses high for one cycle. If no entry is live, it pulses in the request cycle itself.
- R7: If a store is accepted in the same cycle as a Fence request, the Fence does not complete until that store has also completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store waiting for write permission requests an entry |
| st_addr | input | ADDR_W | Store address |
| st_idx | output | IDX_W | Entry index given to the store in this cycle |
| done_valid | input | 1 | The cache reports that a pending store has completed |
| done_idx | input | IDX_W | Index of the completed entry |
| ld_valid | input | 1 | A load is issuing |
| ld_addr | input | ADDR_W | Load address |
| ld_stall | output | 1 | The load matches a pending store and must wait |
| fence_req | input | 1 | Fence request pulse |
| fence_done | output | 1 | One-cycle pulse: the Fence has completed |
| full | output | 1 | All entries are live; new stores must be held back |

## Verification
The assertions check the following on every cycle:
- an accepted store becomes live at its reported index;
- a completed live entry is freed;
- a store request made while full leaves the entries unchanged;
- a stall never occurs without a load;
- no entry is live in the cycle after `fence_done`.

Other behaviours appear only in the bench's scenarios:
- the same-cycle orderings, where a completion races a load or an allocation meets a Fence;
- the lowest-free choice of index after entries are freed out of order;
- duplicate addresses;
- a store ignored while full, which must never cause a stall later.

// File: rtl/store_addr_tracker.sv
module store_addr_tracker #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W = 32,
  parameter int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  output logic [IDX_W-1:0]  st_idx,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_stall,
  input  logic              fence_req,
  output logic              fence_done,
  output logic              full
);

  logic [NUM_ENTRIES-1:0] valid, valid_n, set_m, clr_m, hit;
  logic [ADDR_W-1:0]      addr_q [NUM_ENTRIES];
  logic                   fence_pend, fence_act, st_fire;

  assign full     = &valid;
  assign st_fire  = st_valid & ~full;

  always_comb begin
    st_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) st_idx = IDX_W'(i);
  end

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (st_fire) set_m[st_idx] = 1'b1;
    if (done_valid) clr_m[done_idx] = 1'b1;
  end

  assign valid_n = (valid & ~clr_m) | set_m;

  always_comb
    for (int i = 0; i < NUM_ENTRIES; i++)
      hit[i] = valid[i] & ~clr_m[i] & (addr_q[i] == ld_addr);

  assign ld_stall   = ld_valid & |hit;
  assign fence_act  = fence_req | fence_pend;
  assign fence_done = fence_act & ~|valid_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid      <= '0;
      fence_pend <= 1'b0;
    end else begin
      valid      <= valid_n;
      fence_pend <= fence_act & ~fence_done;
    end
  end

  always_ff @(posedge clk)
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (set_m[i]) addr_q[i] <= st_addr;

endmodule

// File: rtl/store_addr_tracker_chk.sv
module store_addr_tracker_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   st_valid,
  input logic [IDX_W-1:0]       st_idx,
  input logic                   done_valid,
  input logic [IDX_W-1:0]       done_idx,
  input logic                   ld_valid,
  input logic                   ld_stall,
  input logic                   fence_done,
  input logic                   full,
  input logic [NUM_ENTRIES-1:0] valid
);

  assert_alloc_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !full) |=> valid[$past(st_idx)]);

  assert_full_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && st_valid && !done_valid) |=> $stable(valid));

  assert_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> ($countones(valid) == NUM_ENTRIES));

  assert_stall_needs_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> ld_valid);

  assert_done_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && valid[done_idx]) |=> !valid[$past(done_idx)]);

  assert_fence_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |=> (valid == '0));

endmodule

bind store_addr_tracker store_addr_tracker_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_idx(st_idx),
  .done_valid(done_valid), .done_idx(done_idx), .ld_valid(ld_valid),
  .ld_stall(ld_stall), .fence_done(fence_done), .full(full), .valid(valid)
);

// File: tb/sim_store_addr_tracker.sv
module sim_store_addr_tracker;
  localparam int N = 4;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int NV = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, done_valid = 1'b0, ld_valid = 1'b0, fence_req = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [IW-1:0] done_idx = '0;
  logic [IW-1:0] st_idx;
  logic ld_stall, fence_done, full;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  store_addr_tracker #(.NUM_ENTRIES(N), .ADDR_W(AW), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_idx(st_idx), .done_valid(done_valid), .done_idx(done_idx),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_stall(ld_stall),
    .fence_req(fence_req), .fence_done(fence_done), .full(full));

  // Fields: st_v st_a done_v done_i ld_v ld_a fence | exp_stall exp_fd exp_full exp_idx
  localparam logic [26:0] VEC [NV] = '{
    {1'b1,8'h10,1'b0,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd0},
    {1'b1,8'h20,1'b0,2'd0,1'b1,8'h10,1'b0, 1'b1,1'b0,1'b0,2'd1},
    {1'b0,8'h00,1'b0,2'd0,1'b1,8'h30,1'b1, 1'b0,1'b0,1'b0,2'd0},
    {1'b0,8'h00,1'b1,2'd0,1'b1,8'h10,1'b0, 1'b0,1'b0,1'b0,2'd0},
    {1'b0,8'h00,1'b0,2'd0,1'b1,8'h20,1'b0, 1'b1,1'b0,1'b0,2'd0},
    {1'b0,8'h00,1'b1,2'd1,1'b1,8'h20,1'b0, 1'b0,1'b1,1'b0,2'd0},
    {1'b0,8'h00,1'b0,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd0},
    {1'b1,8'h40,1'b0,2'd0,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,2'd0},
    {1'b0,8'h00,1'b0,2'd0,1'b1,8'h40,1'b0, 1'b1,1'b0,1'b0,2'd0},
    {1'b0,8'h00,1'b1,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b0,2'd0},
    {1'b1,8'h50,1'b0,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd0},
    {1'b1,8'h51,1'b0,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd1},
    {1'b1,8'h52,1'b0,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd2},
    {1'b1,8'h53,1'b0,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd3},
    {1'b1,8'h60,1'b0,2'd0,1'b1,8'h60,1'b0, 1'b0,1'b0,1'b1,2'd0},
    {1'b0,8'h00,1'b1,2'd2,1'b1,8'h60,1'b0, 1'b0,1'b0,1'b1,2'd0},
    {1'b1,8'h70,1'b0,2'd0,1'b1,8'h52,1'b0, 1'b0,1'b0,1'b0,2'd2},
    {1'b0,8'h00,1'b0,2'd0,1'b1,8'h70,1'b0, 1'b1,1'b0,1'b1,2'd0},
    {1'b0,8'h00,1'b0,2'd0,1'b0,8'h70,1'b0, 1'b0,1'b0,1'b1,2'd0},
    {1'b0,8'h00,1'b0,2'd0,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b1,2'd0},
    {1'b0,8'h00,1'b1,2'd1,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,2'd0},
    {1'b0,8'h00,1'b1,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd0},
    {1'b0,8'h00,1'b1,2'd2,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd0},
    {1'b0,8'h00,1'b1,2'd3,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b0,2'd0},
    {1'b0,8'h00,1'b1,2'd0,1'b0,8'h00,1'b1, 1'b0,1'b1,1'b0,2'd0},
    {1'b1,8'h80,1'b0,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd0},
    {1'b1,8'h80,1'b0,2'd0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,2'd1},
    {1'b0,8'h00,1'b1,2'd0,1'b1,8'h80,1'b0, 1'b1,1'b0,1'b0,2'd0},
    {1'b0,8'h00,1'b1,2'd1,1'b1,8'h80,1'b0, 1'b0,1'b0,1'b0,2'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    st_valid = 0; done_valid = 0; ld_valid = 0; fence_req = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", "stall in reset", ld_stall, 0);
    chk("R1", "full in reset", full, 0);
    chk("R1", "fence_done in reset", fence_done, 0);
    rst_n = 1;
    #1;
    chk("R1", "full after reset", full, 0);

    for (int k = 0; k < NV; k++) begin
      {st_valid, st_addr, done_valid, done_idx, ld_valid, ld_addr, fence_req} = VEC[k][26:5];
      #1;
      chk("R4", $sformatf("stall v%0d", k), ld_stall, VEC[k][4]);
      chk("R6", $sformatf("fence_done v%0d", k), fence_done, VEC[k][3]);
      chk("R3", $sformatf("full v%0d", k), full, VEC[k][2]);
      if (VEC[k][26] && !VEC[k][2])
        chk("R2", $sformatf("st_idx v%0d", k), st_idx, VEC[k][1:0]);
      @(negedge clk);
    end
    idle();

    // R7 with fence pending across cycles, R5 free-entry completion
    st_valid = 1; st_addr = 8'h90; fence_req = 1; #1;
    chk("R7", "fence with same-cycle store", fence_done, 0);
    @(negedge clk); idle();
    done_valid = 1; done_idx = 2'd3; ld_valid = 1; ld_addr = 8'h90; #1;
    chk("R5", "free-entry completion ignored", ld_stall, 1);
    chk("R7", "fence still waits", fence_done, 0);
    @(negedge clk); idle();
    done_valid = 1; done_idx = 2'd0; #1;
    chk("R7", "fence done after store completes", fence_done, 1);
    @(negedge clk); idle(); #1;
    chk("R6", "fence_done single pulse", fence_done, 0);

    // R1: reset with live entries
    st_valid = 1; st_addr = 8'hA0;
    @(negedge clk); st_addr = 8'hA1;
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1;
    ld_valid = 1; ld_addr = 8'hA0; #1;
    chk("R1", "no stall after reset", ld_stall, 0);
    st_valid = 1; #1;
    chk("R1", "entry 0 free after reset", st_idx, 0);
    @(negedge clk); idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule